// File: doc/BRIEF.md
# Timer Capture/Compare Channel Array

A bank of four identical channels attached to one free-running 16-bit timer. Each channel holds a 16-bit data register and works in one of two modes. In capture mode, a selected trigger copies the current timer count into the data register. In the same cycle the channel records the count direction. The trigger can be an edge on the channel's own pin, an overflow strobe from one of two other timers, or a comparator event strobe. In compare mode, the channel fires when its data register equals the timer count, and it can ask the timer to restart from zero.

Software reaches the block through a byte-wide register port. Each channel has four byte slots, and one shared flag register follows them. Compare values are written into a shadow pair of bytes. The pair moves into the active register as a unit, so the comparator never sees a half-written value. Any capture or compare event latches a per-channel flag. An enabled flag drives the single interrupt output.

Top module: `tcc_array`

## Requirements
- R1: After reset every data register, control field, direction bit and flag reads 0, and `irq_o` and `tmr_clr_o` are 0.
- R2: Each pin passes through two synchronizing flops and then one delay flop. Trigger code 1 captures on a rising edge, code 2 on a falling edge and code 3 on either edge. A pin change made just after clock edge k loads the count present at edge k+3.
- R3: Trigger code 4 captures on `ovf_a_i` and code 5 on `ovf_b_i`. Code 6 captures on `cmp_evt_i`. Codes 0 and 7 never capture. A strobe present at a clock edge loads the count at that edge, and it has no effect on a channel in compare mode.
- R4: There is no overrun protection. Every capture overwrites the data register whether or not the previous value was read.
- R5: At each capture the direction bit (control bit 6) stores `tmr_dn_i` when `tmr_dual_i` is 1, and stores 0 otherwise. Up is 0 and down is 1.
- R6: In compare mode (control bit 0) a channel matches while its active data equals `tmr_cnt_i`, and each match cycle sets its flag. `tmr_clr_o` is high in the same cycle as any match whose channel has clear-on-compare (control bit 1) set.
- R7: Writes to the low data byte (slot 0) and the high data byte (slot 1) go to a shadow pair and mark a load as pending. A pending load reaches the active register at the next edge when the channel is in capture mode, or at an edge where `tmr_cnt_i` is 0 when it is in compare mode. A capture in that cycle takes precedence.
- R8: The flag register sits at address 16, with flag c in bit c. Writing 1 to a bit clears that flag, and writing 0 leaves it. A set and a clear in the same cycle leave the flag set.
- R9: `irq_o` is the OR over channels of flag AND interrupt enable (control bit 5).
- R10: Channel c occupies addresses 4c to 4c+3. Slot 0 reads the active low byte and slot 1 the active high byte. Slot 2 holds control: bit 0 mode, bit 1 clear-on-compare, bits 4:2 trigger code, bit 5 enable, bit 6 direction (read-only), bit 7 zero. Slot 3 and unmapped addresses read 0, and `rdata_o` follows `addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tmr_cnt_i | input | 16 | Current timer count |
| tmr_dn_i | input | 1 | Timer counting down (1) or up (0) |
| tmr_dual_i | input | 1 | Timer in up/down mode |
| cap_pin_i | input | 4 | External capture pins, one per channel |
| ovf_a_i | input | 1 | Overflow strobe of first other timer |
| ovf_b_i | input | 1 | Overflow strobe of second other timer |
| cmp_evt_i | input | 1 | Comparator event strobe |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| flag_o | output | 4 | Per-channel event flags |
| irq_o | output | 1 | Interrupt request |
| tmr_clr_o | output | 1 | Request to clear the timer |

## Verification
A flag can be set by a capture or a compare and cleared by a write in the same cycle. The bench provokes this in two ways. It drives random write-one-to-clear traffic while pins and strobes are busy. It also runs a phase in which an overflow strobe triggers a capture on every cycle while the flag register is cleared on about half of the cycles. A behavioural model applies set-over-clear on each edge, and the bench compares the flags, the interrupt and the read data with that model after every clock. A second such collision occurs when a shadow load is pending and a capture arrives on the same edge. Random traffic covers it, and the model applies capture precedence.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [2:0] {
    TRG_OFF  = 3'd0,
    TRG_RISE = 3'd1,
    TRG_FALL = 3'd2,
    TRG_ANY  = 3'd3,
    TRG_OVA  = 3'd4,
    TRG_OVB  = 3'd5,
    TRG_CMP  = 3'd6,
    TRG_RSV  = 3'd7
  } trig_e;

  typedef struct packed {
    logic  ien;
    trig_e trig;
    logic  clr_en;
    logic  cmp_mode;
  } ctl_t;

  localparam int SLOTS    = 4;
  localparam int SLOT_LO  = 0;
  localparam int SLOT_HI  = 1;
  localparam int SLOT_CTL = 2;
endpackage

// File: rtl/tcc_edge_det.sv
module tcc_edge_det #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC-1:0], pin_i};
  end

  assign rise_o =  sh_q[SYNC-1] & ~sh_q[SYNC];
  assign fall_o = ~sh_q[SYNC-1] &  sh_q[SYNC];
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] tmr_cnt_i,
  input  logic          tmr_dn_i,
  input  logic          tmr_dual_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          ova_i,
  input  logic          ovb_i,
  input  logic          cmpev_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic          wr_ctl_i,
  input  logic [BW-1:0] wdata_i,
  output logic [CW-1:0] data_o,
  output ctl_t          ctl_o,
  output logic          dir_o,
  output logic          set_o,
  output logic          clr_req_o
);
  localparam int CTLW = $bits(ctl_t);

  logic [CW-1:0] act_q, shd_q;
  logic          pend_q, dir_q;
  ctl_t          ctl_q;
  logic          trg, cap, hit, xfer;

  always_comb begin
    unique case (ctl_q.trig)
      TRG_RISE: trg = rise_i;
      TRG_FALL: trg = fall_i;
      TRG_ANY:  trg = rise_i | fall_i;
      TRG_OVA:  trg = ova_i;
      TRG_OVB:  trg = ovb_i;
      TRG_CMP:  trg = cmpev_i;
      default:  trg = 1'b0;
    endcase
  end

  assign cap  = ~ctl_q.cmp_mode & trg;
  assign hit  = ctl_q.cmp_mode & (act_q == tmr_cnt_i);
  // shadow pair moves as a unit; in compare mode only at timer zero
  assign xfer = pend_q & (~ctl_q.cmp_mode | (tmr_cnt_i == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      shd_q  <= '0;
      pend_q <= 1'b0;
      dir_q  <= 1'b0;
      ctl_q  <= '0;
    end else begin
      if (cap)       act_q <= tmr_cnt_i;
      else if (xfer) act_q <= shd_q;
      if (cap) dir_q <= tmr_dual_i & tmr_dn_i;
      if (wr_lo_i) shd_q[BW-1:0]  <= wdata_i;
      if (wr_hi_i) shd_q[CW-1:BW] <= wdata_i;
      pend_q <= (pend_q & ~xfer) | wr_lo_i | wr_hi_i;
      if (wr_ctl_i) ctl_q <= ctl_t'(wdata_i[CTLW-1:0]);
    end
  end

  assign data_o    = act_q;
  assign ctl_o     = ctl_q;
  assign dir_o     = dir_q;
  assign set_o     = cap | hit;
  assign clr_req_o = hit & ctl_q.clr_en;
endmodule

// File: rtl/tcc_flags.sv
module tcc_flags #(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic           clr_wr_i,
  input  logic [NCH-1:0] clr_mask_i,
  input  logic [NCH-1:0] ien_i,
  output logic [NCH-1:0] flag_o,
  output logic           irq_o
);
  logic [NCH-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~({NCH{clr_wr_i}} & clr_mask_i)) | set_i;
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & ien_i);
endmodule

// File: rtl/tcc_array.sv
module tcc_array
  import tcc_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CW   = 16,
  parameter int BW   = 8,
  parameter int SYNC = 2,
  parameter int AW   = $clog2(NCH*SLOTS + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [CW-1:0]  tmr_cnt_i,
  input  logic           tmr_dn_i,
  input  logic           tmr_dual_i,
  input  logic [NCH-1:0] cap_pin_i,
  input  logic           ovf_a_i,
  input  logic           ovf_b_i,
  input  logic           cmp_evt_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [BW-1:0]  wdata_i,
  output logic [BW-1:0]  rdata_o,
  output logic [NCH-1:0] flag_o,
  output logic           irq_o,
  output logic           tmr_clr_o
);
  localparam int FLAG_ADDR = NCH * SLOTS;
  localparam int CTLW      = $bits(ctl_t);

  logic [NCH-1:0] ch_set, ch_clr_req, ch_ien, ch_mode, ch_clr, ch_dir;
  logic [CW-1:0]  ch_data [NCH];
  ctl_t           ch_ctl  [NCH];
  logic           wr_flag;

  assign wr_flag = wr_en_i && (addr_i == AW'(FLAG_ADDR));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic rise, fall, wr_lo, wr_hi, wr_ctl;

    assign wr_lo  = wr_en_i && (addr_i == AW'(c*SLOTS + SLOT_LO));
    assign wr_hi  = wr_en_i && (addr_i == AW'(c*SLOTS + SLOT_HI));
    assign wr_ctl = wr_en_i && (addr_i == AW'(c*SLOTS + SLOT_CTL));

    tcc_edge_det #(.SYNC(SYNC)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_pin_i[c]),
      .rise_o (rise),
      .fall_o (fall)
    );

    tcc_channel #(.CW(CW), .BW(BW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tmr_cnt_i  (tmr_cnt_i),
      .tmr_dn_i   (tmr_dn_i),
      .tmr_dual_i (tmr_dual_i),
      .rise_i     (rise),
      .fall_i     (fall),
      .ova_i      (ovf_a_i),
      .ovb_i      (ovf_b_i),
      .cmpev_i    (cmp_evt_i),
      .wr_lo_i    (wr_lo),
      .wr_hi_i    (wr_hi),
      .wr_ctl_i   (wr_ctl),
      .wdata_i    (wdata_i),
      .data_o     (ch_data[c]),
      .ctl_o      (ch_ctl[c]),
      .dir_o      (ch_dir[c]),
      .set_o      (ch_set[c]),
      .clr_req_o  (ch_clr_req[c])
    );

    assign ch_ien[c]  = ch_ctl[c].ien;
    assign ch_mode[c] = ch_ctl[c].cmp_mode;
    assign ch_clr[c]  = ch_ctl[c].clr_en;
  end

  tcc_flags #(.NCH(NCH)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (ch_set),
    .clr_wr_i   (wr_flag),
    .clr_mask_i (wdata_i[NCH-1:0]),
    .ien_i      (ch_ien),
    .flag_o     (flag_o),
    .irq_o      (irq_o)
  );

  assign tmr_clr_o = |ch_clr_req;

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(FLAG_ADDR)) begin
      rdata_o[NCH-1:0] = flag_o;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (int'(addr_i[AW-1:2]) == c) begin
          unique case (int'(addr_i[1:0]))
            SLOT_LO:  rdata_o = ch_data[c][BW-1:0];
            SLOT_HI:  rdata_o = ch_data[c][CW-1:BW];
            SLOT_CTL: rdata_o = BW'({ch_dir[c], ch_ctl[c]});
            default:  rdata_o = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tcc_array_chk.sv
module tcc_array_chk #(
  parameter int NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] flag_o,
  input logic           irq_o,
  input logic           tmr_clr_o,
  input logic [NCH-1:0] flag_set,
  input logic [NCH-1:0] ien,
  input logic [NCH-1:0] mode,
  input logic [NCH-1:0] clr_en,
  input logic           wr_flag,
  input logic [NCH-1:0] wmask
);
  AST_IRQ_FROM_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(flag_o & ien)); // R9

  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o & ~$past(flag_o) & ~$past(flag_set)) == '0); // R6

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_set) |=> ((flag_o & $past(flag_set)) == $past(flag_set))); // R8

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_flag |=> ((flag_o & $past(wmask) & ~$past(flag_set)) == '0)); // R8

  AST_CLR_NEEDS_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_clr_o |-> |(mode & clr_en)); // R6
endmodule

bind tcc_array tcc_array_chk #(.NCH(NCH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .flag_o    (flag_o),
  .irq_o     (irq_o),
  .tmr_clr_o (tmr_clr_o),
  .flag_set  (ch_set),
  .ien       (ch_ien),
  .mode      (ch_mode),
  .clr_en    (ch_clr),
  .wr_flag   (wr_flag),
  .wmask     (wdata_i[NCH-1:0])
);

// File: tb/tcc_array_tb.sv
`timescale 1ns/1ps
module tcc_array_tb;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] tmr_cnt;
  logic        tmr_dn, tmr_dual;
  logic [3:0]  pins;
  logic        ova, ovb, cmpe;
  logic        wr_en;
  logic [4:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [3:0]  flag;
  logic        irq, tclr;

  always #10 clk = ~clk;

  tcc_array u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tmr_cnt_i(tmr_cnt), .tmr_dn_i(tmr_dn),
    .tmr_dual_i(tmr_dual), .cap_pin_i(pins), .ovf_a_i(ova), .ovf_b_i(ovb),
    .cmp_evt_i(cmpe), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .flag_o(flag), .irq_o(irq), .tmr_clr_o(tclr)
  );

  int    n_vec = 0, n_bad = 0;
  string cur_req = "R1";
  int    hold [4];
  int    raddr = 0;

  // behavioural reference model
  logic [15:0] m_act [4], m_sh [4];
  logic        m_pend [4], m_dir [4], m_mode [4], m_clr [4], m_ien [4];
  logic [2:0]  m_trig [4];
  logic        p1 [4], p2 [4], p3 [4];
  logic [3:0]  m_flag;
  logic [3:0]  setv;
  logic        t_hit, t_rise, t_fall, t_trg, t_cap, t_xf;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 4; c++) begin
        m_act[c] = 0; m_sh[c] = 0; m_pend[c] = 0; m_dir[c] = 0;
        m_mode[c] = 0; m_clr[c] = 0; m_ien[c] = 0; m_trig[c] = 0;
        p1[c] = 0; p2[c] = 0; p3[c] = 0;
      end
      m_flag = 0;
    end else begin
      setv = 0;
      for (int c = 0; c < 4; c++) begin
        t_rise = p2[c] & ~p3[c];
        t_fall = ~p2[c] & p3[c];
        case (m_trig[c])
          1: t_trg = t_rise;
          2: t_trg = t_fall;
          3: t_trg = t_rise | t_fall;
          4: t_trg = ova;
          5: t_trg = ovb;
          6: t_trg = cmpe;
          default: t_trg = 0;
        endcase
        t_cap = !m_mode[c] && t_trg;
        t_hit = m_mode[c] && (m_act[c] == tmr_cnt);
        t_xf  = m_pend[c] && (!m_mode[c] || tmr_cnt == 0);
        if (t_cap) begin
          m_act[c] = tmr_cnt;
          m_dir[c] = tmr_dual & tmr_dn;
        end else if (t_xf) m_act[c] = m_sh[c];
        if (t_xf) m_pend[c] = 0;
        setv[c] = t_cap | t_hit;
        p3[c] = p2[c]; p2[c] = p1[c]; p1[c] = pins[c];
      end
      if (wr_en && addr == 16) m_flag = m_flag & ~wdata[3:0];
      m_flag = m_flag | setv;
      if (wr_en && addr < 16) begin
        case (addr[1:0])
          0: begin m_sh[addr[3:2]][7:0]  = wdata; m_pend[addr[3:2]] = 1; end
          1: begin m_sh[addr[3:2]][15:8] = wdata; m_pend[addr[3:2]] = 1; end
          2: begin
            m_mode[addr[3:2]] = wdata[0];
            m_clr[addr[3:2]]  = wdata[1];
            m_trig[addr[3:2]] = wdata[4:2];
            m_ien[addr[3:2]]  = wdata[5];
          end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rd(logic [4:0] a);
    if (a == 16) return {4'b0, m_flag};
    if (a > 16) return 8'h00;
    case (a[1:0])
      0: return m_act[a[3:2]][7:0];
      1: return m_act[a[3:2]][15:8];
      2: return {1'b0, m_dir[a[3:2]], m_ien[a[3:2]], m_trig[a[3:2]],
                 m_clr[a[3:2]], m_mode[a[3:2]]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_clr();
    logic r = 0;
    for (int c = 0; c < 4; c++)
      if (m_mode[c] && m_clr[c] && m_act[c] == tmr_cnt) r = 1;
    return r;
  endfunction

  function automatic logic exp_irq();
    logic r = 0;
    for (int c = 0; c < 4; c++) if (m_flag[c] && m_ien[c]) r = 1;
    return r;
  endfunction

  task automatic cmp(string what, logic [7:0] got, logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
    end
  endtask

  task automatic tick();
    logic c_now;
    @(negedge clk);
    c_now = exp_clr();
    cmp("rdata", rdata, exp_rd(addr));
    cmp("flag", {4'b0, flag}, {4'b0, m_flag});
    cmp("irq", {7'b0, irq}, {7'b0, exp_irq()});
    cmp("tmr_clr", {7'b0, tclr}, {7'b0, c_now});
    tmr_cnt = c_now ? 16'h0 : tmr_cnt + 16'h1;
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    tick();
    wr_en = 0;
  endtask

  task automatic run(int n, int clr_pct, int str_pct);
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < 4; c++) begin
        hold[c]++;
        if (hold[c] >= 2 && $urandom_range(99) < 40) begin
          pins[c] = ~pins[c];
          hold[c] = 0;
        end
      end
      ova    = $urandom_range(99) < str_pct;
      ovb    = $urandom_range(99) < str_pct;
      cmpe   = $urandom_range(99) < str_pct;
      tmr_dn = 1'($urandom_range(1));
      if ($urandom_range(99) < clr_pct) begin
        wr_en = 1; addr = 16; wdata = 8'($urandom_range(255));
      end else begin
        wr_en = 0; addr = 5'(raddr);
        raddr = (raddr == 17) ? 0 : raddr + 1;
      end
      tick();
    end
    wr_en = 0; ova = 0; ovb = 0; cmpe = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 0; tmr_cnt = 0; tmr_dn = 0; tmr_dual = 0; pins = 0;
    ova = 0; ovb = 0; cmpe = 0; wr_en = 0; addr = 0; wdata = 0;
    for (int c = 0; c < 4; c++) hold[c] = 0;
    // R1: reset state
    cur_req = "R1";
    tick(); tick();
    rst_ni = 1;
    for (int a = 0; a < 18; a++) begin addr = 5'(a); tick(); end

    // R10: register map readback
    cur_req = "R10";
    wr(2, 8'h24); wr(6, 8'h28); wr(10, 8'h2C); wr(14, 8'h1C);
    for (int a = 0; a < 18; a++) begin addr = 5'(a); tick(); end

    // R2: pin edge selection and synchronizer latency
    cur_req = "R2";
    wr(14, 8'h00);
    run(400, 5, 0);

    // R4: back-to-back captures overwrite without reads
    cur_req = "R4";
    run(200, 0, 0);

    // R3: internal strobes as triggers
    cur_req = "R3";
    wr(2, 8'h10); wr(6, 8'h14); wr(10, 8'h18); wr(14, 8'h2C);
    run(300, 5, 30);

    // R5: direction capture in up/down mode
    cur_req = "R5";
    tmr_dual = 1;
    run(300, 5, 30);
    tmr_dual = 0;

    // R7: shadow load in capture mode, then compare mode at wrap
    cur_req = "R7";
    wr(12, 8'h55); addr = 12; tick();
    wr(13, 8'hAA); addr = 13; tick();
    wr(2, 8'h21);
    wr(0, 8'h80); wr(1, 8'h01);
    addr = 0; tick(); addr = 1; tick();
    tmr_cnt = 16'hFFF8;
    for (int i = 0; i < 40; i++) begin addr = 5'(i % 3); tick(); end
    tmr_cnt = 16'h0170;
    run(40, 0, 0);

    // R6: compare match with timer clear
    cur_req = "R6";
    wr(4, 8'h30); wr(5, 8'h00);
    wr(6, 8'h23);
    run(300, 10, 0);

    // R8: capture every cycle against frequent clears
    cur_req = "R8";
    wr(6, 8'h14); wr(10, 8'h10);
    for (int i = 0; i < 100; i++) begin
      ova = 1;
      if (i % 2 == 0) begin wr_en = 1; addr = 16; wdata = 8'h0F; end
      else begin wr_en = 0; addr = 16; end
      tick();
    end
    wr_en = 0; ova = 0;

    // R9: interrupt enable gating
    cur_req = "R9";
    wr(2, 8'h00); wr(10, 8'h30); wr(14, 8'h0C);
    run(100, 20, 20);
    wr(10, 8'h10); wr(14, 8'h2C);
    run(100, 20, 20);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule